// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block decides, cycle by cycle, whether a small 8-bit core may issue instructions, must stay stopped, must give the bus away, or may take a maskable interrupt. The decoder sends a strobe for each of four instruction kinds: enable interrupts, disable interrupts, halt and no-operation. A separate completion pulse marks the end of every instruction. From these inputs the block keeps the interrupt-enable flag, together with a delayed-enable flag that an enable instruction arms. It also tracks four states: running, halted, held from running and held from halted.

Enabling takes effect only once the instruction after the enable instruction has finished. Disabling takes effect at the boundary where the disable instruction finishes. A halt stops issue until an accepted interrupt or a reset. A bus hold can be granted from either running or halted, and when it is released the core returns to the state it was in before the hold. Every output comes from a register, so the core sees a decision one clock after the boundary that caused it.

Top module: `iec_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `run_en` is 1. At that point `halted`, `hold_ack` and `int_ack` are 0, and interrupt enable and any pending delayed-enable are cleared.
- R2: A disable strobe at an instruction boundary blocks acceptance of an interrupt requested in that same cycle, and of any interrupt requested at later boundaries.
- R3: An enable strobe arms a delayed-enable. An interrupt cannot be accepted at the enable instruction's own boundary. The earliest boundary where one can be accepted is the completion of the next instruction.
- R4: A disable strobe that arrives while a delayed-enable is pending cancels that pending enable.
- R5: A halt strobe at a boundary sets `halted` to 1 and `run_en` to 0 on the next edge, unless an interrupt is accepted at that same boundary. While `halted` is 1, the completion pulse and all strobes have no effect.
- R6: An accepted interrupt raises `int_ack` for exactly one cycle, on the edge after the accepting boundary, and clears interrupt enable.
- R7: From the halted state, the core returns to running (`halted`=0, `run_en`=1) only when an interrupt is accepted while interrupts are enabled, or on reset.
- R8: `hold_ack` rises only when `hold_req` is seen at an instruction boundary or while halted. It stays at 1 for as long as `hold_req` stays at 1, and falls on the edge after `hold_req` drops.
- R9: A hold granted from the halted state returns to halted (`halted`=1, `run_en`=0) when it is released.
- R10: Reset aborts the halted state and the held states, and returns the core to running.
- R11: A no-operation strobe counts as an instruction completion, which also completes an enable delay, and has no other effect.
- R12: When a hold request and an eligible interrupt request arrive at the same boundary, the hold wins. No interrupt is accepted while the hold is granted.
- R13: Enable, disable and halt strobes have no effect unless the completion pulse (or a no-operation strobe) is present in the same cycle while running.

Instruction boundary: a cycle with `run_en`=1 and either `instr_done` or `nop_stb` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ei_stb | input | 1 | Enable-interrupts instruction is completing |
| di_stb | input | 1 | Disable-interrupts instruction is completing |
| hlt_stb | input | 1 | Halt instruction is completing |
| nop_stb | input | 1 | No-operation instruction is completing (counts as a completion) |
| instr_done | input | 1 | Any instruction completes this cycle |
| int_req | input | 1 | Maskable interrupt request level |
| hold_req | input | 1 | Bus hold request level |
| int_ack | output | 1 | One-cycle interrupt acknowledge |
| hold_ack | output | 1 | Bus hold granted |
| halted | output | 1 | Core is halted (also during a hold taken from halt) |
| run_en | output | 1 | Core may issue instructions |

## Verification
The bench sends an interrupt request into the boundary of an enable instruction. A design that enabled at once would acknowledge there instead of one instruction later. It places a disable behind an enable and expects no acknowledge at all. A design that let the armed enable survive the disable would acknowledge. It grants a hold from halt and releases it, which catches a design that falls back to running. Hold and an interrupt arrive together at one boundary, and a design with the wrong priority would acknowledge while the bus is given away. Random strobe, request and hold patterns then compare all four outputs each cycle against a bench model.

// File: rtl/iec_pkg.sv
package iec_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_HALT      = 2'd1,
    ST_HOLD_RUN  = 2'd2,
    ST_HOLD_HALT = 2'd3
  } iec_state_e;
endpackage

// File: rtl/iec_enable.sv
// Interrupt-enable flag, delayed-enable flag and acceptance decision.
module iec_enable (
  input  logic clk,
  input  logic rst,
  input  logic run_bound,
  input  logic halt_idle,
  input  logic hold_req,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic int_req,
  output logic accept
);
  logic ie_q, pend_q;
  logic di_now, ei_now, en_eff;

  always_comb begin
    di_now = run_bound & di_stb;
    ei_now = run_bound & ei_stb;
    // a pending enable counts once the following instruction completes
    en_eff = ie_q | (pend_q & run_bound);
    accept = int_req & en_eff & ~di_now & ~hold_req & (run_bound | halt_idle);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (accept || di_now) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (run_bound) begin
      if (pend_q) ie_q <= 1'b1;
      pend_q <= ei_now;
    end
  end
endmodule

// File: rtl/iec_fsm.sv
// Run / halt / hold sequencing with registered output decodes.
module iec_fsm
  import iec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_bound,
  input  logic hlt_stb,
  input  logic hold_req,
  input  logic accept,
  output logic run_en,
  output logic halted,
  output logic hold_ack,
  output logic halt_idle
);
  iec_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (run_bound) begin
          if (hold_req)     st_d = hlt_stb ? ST_HOLD_HALT : ST_HOLD_RUN;
          else if (accept)  st_d = ST_RUN;
          else if (hlt_stb) st_d = ST_HALT;
        end
      end
      ST_HALT: begin
        if (hold_req)    st_d = ST_HOLD_HALT;
        else if (accept) st_d = ST_RUN;
      end
      ST_HOLD_RUN:  if (!hold_req) st_d = ST_RUN;
      ST_HOLD_HALT: if (!hold_req) st_d = ST_HALT;
      default:      st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_RUN;
      run_en    <= 1'b1;
      halted    <= 1'b0;
      hold_ack  <= 1'b0;
      halt_idle <= 1'b0;
    end else begin
      st_q      <= st_d;
      run_en    <= (st_d == ST_RUN);
      halted    <= (st_d == ST_HALT) || (st_d == ST_HOLD_HALT);
      hold_ack  <= (st_d == ST_HOLD_RUN) || (st_d == ST_HOLD_HALT);
      halt_idle <= (st_d == ST_HALT);
    end
  end
endmodule

// File: rtl/iec_ctrl.sv
// Top: interrupt acceptance plus halt and hold control.
module iec_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic hlt_stb,
  input  logic nop_stb,
  input  logic instr_done,
  input  logic int_req,
  input  logic hold_req,
  output logic int_ack,
  output logic hold_ack,
  output logic halted,
  output logic run_en
);
  logic run_bound, halt_idle, accept;

  // a no-operation strobe is itself a completion
  assign run_bound = run_en & (instr_done | nop_stb);

  iec_enable u_en (
    .clk       (clk),
    .rst       (rst),
    .run_bound (run_bound),
    .halt_idle (halt_idle),
    .hold_req  (hold_req),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .int_req   (int_req),
    .accept    (accept)
  );

  iec_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .run_bound (run_bound),
    .hlt_stb   (hlt_stb),
    .hold_req  (hold_req),
    .accept    (accept),
    .run_en    (run_en),
    .halted    (halted),
    .hold_ack  (hold_ack),
    .halt_idle (halt_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) int_ack <= 1'b0;
    else     int_ack <= accept;
  end
endmodule

// File: rtl/iec_ctrl_chk.sv
module iec_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic di_stb,
  input logic nop_stb,
  input logic instr_done,
  input logic hold_req,
  input logic int_ack,
  input logic hold_ack,
  input logic halted,
  input logic run_en
);
  // R6
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !int_ack);

  // R8
  hold_grant_point_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> ($past(hold_req) &&
      ($past(halted) || ($past(run_en) && ($past(instr_done) || $past(nop_stb))))));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);

  // R9
  hold_back_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && halted && !hold_req) |=> (halted && !hold_ack));

  // R5
  halt_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !run_en);

  // R2
  di_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && (instr_done || nop_stb) && di_stb) |=> !int_ack);

  // R12
  no_ack_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> !int_ack);

  // R10
  reset_run_chk: assert property (@(posedge clk)
    rst |=> (run_en && !halted && !hold_ack && !int_ack));
endmodule

bind iec_ctrl iec_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .di_stb     (di_stb),
  .nop_stb    (nop_stb),
  .instr_done (instr_done),
  .hold_req   (hold_req),
  .int_ack    (int_ack),
  .hold_ack   (hold_ack),
  .halted     (halted),
  .run_en     (run_en)
);

// File: tb/iec_ctrl_tb.sv
module iec_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ei_stb = 0, di_stb = 0, hlt_stb = 0, nop_stb = 0;
  logic instr_done = 0, int_req = 0, hold_req = 0;
  logic int_ack, hold_ack, halted, run_en;

  int checks = 0, errors = 0;
  bit fin = 0;

  // bench model: mode 0 run, 1 halt, 2 held from run, 3 held from halt
  bit m_ie, m_pend, m_ack;
  int m_mode;

  always #(CLK_P/2) clk = ~clk;

  iec_ctrl u_dut (
    .clk(clk), .rst(rst), .ei_stb(ei_stb), .di_stb(di_stb), .hlt_stb(hlt_stb),
    .nop_stb(nop_stb), .instr_done(instr_done), .int_req(int_req), .hold_req(hold_req),
    .int_ack(int_ack), .hold_ack(hold_ack), .halted(halted), .run_en(run_en)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit ei, di, hl, nop, dn, irq, hld);
    bit rb, hi, acc;
    int nm;
    rb  = (m_mode == 0) && (dn || nop);
    hi  = (m_mode == 1);
    acc = irq && (m_ie || (m_pend && rb)) && !(rb && di) && !hld && (rb || hi);
    nm = m_mode;
    case (m_mode)
      0: if (rb) begin
           if (hld)      nm = hl ? 3 : 2;
           else if (acc) nm = 0;
           else if (hl)  nm = 1;
         end
      1: if (hld) nm = 3; else if (acc) nm = 0;
      2: if (!hld) nm = 0;
      default: if (!hld) nm = 1;
    endcase
    if (acc || (rb && di)) begin
      m_ie = 0; m_pend = 0;
    end else if (rb) begin
      if (m_pend) m_ie = 1;
      m_pend = ei;
    end
    m_mode = nm;
    m_ack  = acc;
  endtask

  // drive one cycle, advance, compare all outputs with the model
  task automatic cyc(input bit ei, di, hl, nop, dn, irq, hld);
    ei_stb = ei; di_stb = di; hlt_stb = hl; nop_stb = nop;
    instr_done = dn; int_req = irq; hold_req = hld;
    model_step(ei, di, hl, nop, dn, irq, hld);
    @(negedge clk);
    check("R6", "int_ack", int_ack, m_ack);
    check("R8", "hold_ack", hold_ack, (m_mode >= 2));
    check("R5", "halted", halted, (m_mode == 1 || m_mode == 3));
    check("R7", "run_en", run_en, (m_mode == 0));
  endtask

  task automatic do_reset();
    rst = 1;
    ei_stb = 0; di_stb = 0; hlt_stb = 0; nop_stb = 0;
    instr_done = 0; int_req = 0; hold_req = 0;
    m_ie = 0; m_pend = 0; m_ack = 0; m_mode = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1", "run_en", run_en, 1'b1);
    check("R1", "halted", halted, 1'b0);
    check("R1", "hold_ack", hold_ack, 1'b0);
    check("R1", "int_ack", int_ack, 1'b0);
    cyc(0,0,0,0,1,1,0);
    check("R1", "no ack with enable cleared", int_ack, 1'b0);

    // R3 enable delayed by one instruction; R11 no-op completes the delay
    cyc(1,0,0,0,1,1,0);
    check("R3", "ack at enable boundary", int_ack, 1'b0);
    cyc(0,0,0,1,0,1,0);
    check("R3", "ack after next instruction", int_ack, 1'b1);
    check("R11", "no-op counted as completion", int_ack, 1'b1);
    cyc(0,0,0,0,1,1,0);
    check("R6", "ack one cycle, enable cleared", int_ack, 1'b0);

    // R13 strobes ignored without completion
    cyc(1,0,0,0,0,0,0);
    cyc(0,0,0,0,1,0,0);
    cyc(0,0,0,0,1,1,0);
    check("R13", "enable strobe without completion", int_ack, 1'b0);
    cyc(0,0,1,0,0,0,0);
    check("R13", "halt strobe without completion", halted, 1'b0);

    // R2 disable blocks same-cycle request
    cyc(1,0,0,0,1,0,0);
    cyc(0,0,0,0,1,0,0);
    cyc(0,1,0,0,1,1,0);
    check("R2", "ack in disable cycle", int_ack, 1'b0);
    cyc(0,0,0,0,1,1,0);
    check("R2", "ack after disable", int_ack, 1'b0);

    // R4 disable cancels pending enable
    cyc(1,0,0,0,1,0,0);
    cyc(0,1,0,0,1,0,0);
    cyc(0,0,0,0,1,1,0);
    cyc(0,0,0,0,1,1,0);
    check("R4", "pending enable cancelled", int_ack, 1'b0);

    // R5 halt, R7 resume by interrupt
    cyc(1,0,0,0,1,0,0);
    cyc(0,0,1,0,1,0,0);
    check("R5", "halted after halt", halted, 1'b1);
    check("R5", "issue stopped", run_en, 1'b0);
    cyc(0,0,0,1,1,0,0);
    check("R5", "completion ignored while halted", halted, 1'b1);
    cyc(0,0,0,0,0,1,0);
    check("R7", "ack from halt", int_ack, 1'b1);
    check("R7", "resumed", run_en, 1'b1);

    // R9 hold from halt returns to halt; R7 disabled request does not wake
    cyc(0,0,1,0,1,0,0);
    cyc(0,0,0,0,0,0,1);
    check("R9", "hold granted from halt", hold_ack, 1'b1);
    cyc(0,0,0,0,0,0,1);
    check("R8", "hold kept", hold_ack, 1'b1);
    cyc(0,0,0,0,0,0,0);
    check("R9", "back to halted", halted, 1'b1);
    check("R9", "hold released", hold_ack, 1'b0);
    cyc(0,0,0,0,0,1,0);
    check("R7", "disabled request leaves halt", halted, 1'b1);

    // R10 reset aborts halt
    do_reset();
    check("R10", "halt aborted", halted, 1'b0);
    check("R10", "running", run_en, 1'b1);

    // R8 hold only at boundary; R12 hold beats interrupt
    cyc(1,0,0,0,1,0,0);
    cyc(0,0,0,0,1,0,0);
    cyc(0,0,0,0,0,0,1);
    check("R8", "no grant mid-instruction", hold_ack, 1'b0);
    cyc(0,0,0,0,1,1,1);
    check("R12", "hold wins at boundary", hold_ack, 1'b1);
    check("R12", "no ack with hold", int_ack, 1'b0);
    cyc(0,0,0,0,0,1,1);
    check("R12", "no ack during hold", int_ack, 1'b0);
    cyc(0,0,0,0,0,0,0);
    check("R8", "hold dropped", hold_ack, 1'b0);
    check("R8", "back to run", run_en, 1'b1);

    // random traffic against the model
    begin
      bit hld = 0;
      for (int i = 0; i < N_RAND; i++) begin
        int k;
        bit dn, irq, e, d, h, n;
        k = $urandom_range(0, 9);
        e = (k == 0); d = (k == 1); h = (k == 2); n = (k == 3);
        dn = ($urandom_range(0, 2) != 0) && !n;
        irq = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 9) == 0) hld = !hld;
        if ($urandom_range(0, 399) == 0) do_reset();
        else cyc(e, d, h, n, dn, irq, hld);
      end
    end

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule